// File: doc/BRIEF.md
# Word-Spaced Byte Register Adapter

This block places a file of sixteen 8-bit registers on a 32-bit bus that is addressed in words. Each register takes a whole word address, so software steps through the registers with word strides and never forms byte offsets. The register index comes from address bits [5:2]. The two lowest address bits are dropped. The higher bits are decoded outside the block into a single select line. The register byte travels on data lane [7:0] only.

A write stores the low byte of the write data. Bits [31:8] of the write data are discarded. A read returns the selected byte one clock after the request, together with a one-cycle valid strobe. A single zero-fill stage drives bits [31:8] of the returned word to zero, so software needs no masking. While a read request is on the bus, the block raises a narrow-device-responding line. A central zero-fill driver elsewhere in the system can use this line.

Top module: `wordbus_byte_adapter`

## Requirements
- R1: After synchronous reset, all sixteen registers read back as zero, and `rd_valid` and `narrow_rd` are low.
- R2: A cycle with `bus_sel`=1 and `bus_we`=1 stores `bus_wdata[7:0]` into the register whose index is `bus_addr[5:2]`; `bus_wdata[31:8]` has no effect on the stored value.
- R3: Only `bus_addr[5:2]` chooses the register; address bits [1:0] and [31:6] do not change which register is written or read.
- R4: A cycle with `bus_sel`=1 and `bus_we`=0 makes `rd_valid` high in the following cycle, with that register's value on `rd_data[7:0]`.
- R5: `rd_data[31:8]` is zero whenever `rd_valid` is high, and all of `rd_data` is zero whenever `rd_valid` is low.
- R6: `narrow_rd` is high in exactly those cycles where `bus_sel`=1 and `bus_we`=0, and low during writes and idle cycles.
- R7: With `bus_sel`=0 the block ignores `bus_we`, `bus_addr` and `bus_wdata`: no register changes and `rd_valid` stays low in the next cycle.
- R8: A write never raises `rd_valid`. A read of an index that has just been written returns the new byte.
- R9: A read leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Device select decoded from the high address bits |
| bus_we | input | 1 | 1 = write, 0 = read, when selected |
| bus_addr | input | 32 | Word bus byte address; bits [5:2] index the register |
| bus_wdata | input | 32 | Write data; only [7:0] is used |
| rd_data | output | 32 | Read data, byte on [7:0], upper lanes zero-filled |
| rd_valid | output | 1 | One-cycle strobe marking `rd_data` as valid |
| narrow_rd | output | 1 | Narrow device responding to a read this cycle |

## Verification
A corrupted register shows up only when that register is next read. The wrong byte then appears on `rd_data[7:0]` one cycle after the read request. The bench therefore follows every random write with reads of random indices checked against a model. A fault in the index extraction shows up as aliasing between addresses that differ only in bits [1:0] or [31:6]. A broken valid or lane stage shows within one cycle as a late or missing strobe, or as nonzero upper lanes.

// File: rtl/wba_pkg.sv
package wba_pkg;
    localparam int BUS_W    = 32;
    localparam int ADDR_W   = 32;
    localparam int BYTE_W   = 8;
    localparam int NUM_REGS = 16;
    localparam int IDX_LSB  = 2;
    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam int LANES    = BUS_W / BYTE_W;

    typedef logic [IDX_W-1:0]  reg_idx_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [BUS_W-1:0]  word_t;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e kind;
        reg_idx_t  idx;
        byte_t     wbyte;
    } acc_req_t;

    function automatic reg_idx_t word_index(input logic [ADDR_W-1:0] a);
        return a[IDX_LSB +: IDX_W];
    endfunction

    function automatic acc_kind_e classify(input logic sel, input logic we);
        if (!sel)
            return ACC_IDLE;
        return we ? ACC_WRITE : ACC_READ;
    endfunction
endpackage

// File: rtl/wba_decode.sv
module wba_decode
    import wba_pkg::*;
(
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             wdata,
    output acc_req_t          req,
    output logic [NUM_REGS-1:0] wr_onehot,
    output logic              narrow_rd
);
    always_comb begin
        req.kind  = classify(sel, we);
        req.idx   = word_index(addr);
        req.wbyte = wdata[BYTE_W-1:0];
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_wsel
        assign wr_onehot[g] = (req.kind == ACC_WRITE) && (req.idx == reg_idx_t'(g));
    end

    assign narrow_rd = (req.kind == ACC_READ);
endmodule

// File: rtl/wba_regfile.sv
module wba_regfile
    import wba_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_REGS-1:0] wr_onehot,
    input  byte_t               wbyte,
    input  reg_idx_t            rd_idx,
    output byte_t               rd_byte
);
    byte_t store [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)
                store[g] <= '0;
            else if (wr_onehot[g])
                store[g] <= wbyte;
        end
    end

    always_comb rd_byte = store[rd_idx];
endmodule

// File: rtl/wba_zero_fill.sv
module wba_zero_fill
    import wba_pkg::*;
#(
    parameter int DATA_LANE = 0
) (
    input  logic  active,
    input  byte_t lane_in,
    output word_t word_out
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        if (l == DATA_LANE) begin : g_data
            assign word_out[l*BYTE_W +: BYTE_W] = active ? lane_in : '0;
        end else begin : g_fill
            assign word_out[l*BYTE_W +: BYTE_W] = '0;
        end
    end
endmodule

// File: rtl/wordbus_byte_adapter.sv
module wordbus_byte_adapter
    import wba_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  rd_data,
    output logic              rd_valid,
    output logic              narrow_rd
);
    acc_req_t            req;
    logic [NUM_REGS-1:0] wr_onehot;
    byte_t               cur_byte;
    byte_t               rd_q;
    logic                valid_q;

    wba_decode u_decode (
        .sel       (bus_sel),
        .we        (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .req       (req),
        .wr_onehot (wr_onehot),
        .narrow_rd (narrow_rd)
    );

    wba_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_onehot (wr_onehot),
        .wbyte     (req.wbyte),
        .rd_idx    (req.idx),
        .rd_byte   (cur_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            rd_q    <= '0;
        end else begin
            valid_q <= (req.kind == ACC_READ);
            if (req.kind == ACC_READ)
                rd_q <= cur_byte;
        end
    end

    wba_zero_fill #(.DATA_LANE(0)) u_fill (
        .active   (valid_q),
        .lane_in  (rd_q),
        .word_out (rd_data)
    );

    assign rd_valid = valid_q;
endmodule

// File: rtl/wba_checker.sv
module wba_checker
    import wba_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             bus_sel,
    input logic             bus_we,
    input logic [BUS_W-1:0] rd_data,
    input logic             rd_valid,
    input logic             narrow_rd
);
    AST_READ_GIVES_VALID: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we) |=> rd_valid); // R4

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && !bus_we) |=> !rd_valid); // R7

    AST_UPPER_LANES_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (rd_data[BUS_W-1:BYTE_W] == '0)); // R5

    AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> (rd_data == '0)); // R5

    AST_NARROW_LEADS_VALID: assert property (@(posedge clk) disable iff (rst)
        narrow_rd |=> rd_valid); // R6

    AST_NARROW_NOT_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_we || !bus_sel) |-> !narrow_rd); // R6

    AST_WRITE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_we) |=> !rd_valid); // R8
endmodule

bind wordbus_byte_adapter wba_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .narrow_rd (narrow_rd)
);

// File: tb/wordbus_byte_adapter_tb_top.sv
`timescale 1ns/1ps
module wordbus_byte_adapter_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_sel;
    logic        bus_we;
    logic [31:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        narrow_rd;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] model [16];

    always #2.5 clk = ~clk;

    wordbus_byte_adapter dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid), .narrow_rd(narrow_rd)
    );

    function automatic logic [3:0] idx_of(input logic [31:0] a);
        return a[5:2];
    endfunction

    function automatic logic [31:0] expect_word(input logic [7:0] b);
        return {24'h0, b};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // drive at negedge, sample 1 ns after the following posedge
    task automatic do_write(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        #0.5;
        check(narrow_rd == 1'b0, "R6 narrow low on write", {31'h0, narrow_rd}, 32'h0);
        @(posedge clk); #1;
        model[idx_of(a)] = d[7:0];
        check(rd_valid == 1'b0, "R8 no valid after write", {31'h0, rd_valid}, 32'h0);
    endtask

    task automatic do_read(input logic [31:0] a, input string req);
        logic [31:0] exp;
        exp = expect_word(model[idx_of(a)]);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_wdata = $urandom;
        #0.5;
        check(narrow_rd == 1'b1, "R6 narrow high on read", {31'h0, narrow_rd}, 32'h1);
        @(posedge clk); #1;
        check(rd_valid == 1'b1, "R4 valid one cycle later", {31'h0, rd_valid}, 32'h1);
        check(rd_data == exp, req, rd_data, exp);
    endtask

    task automatic do_idle(input logic we, input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = we; bus_addr = a; bus_wdata = d;
        #0.5;
        check(narrow_rd == 1'b0, "R6 narrow low when idle", {31'h0, narrow_rd}, 32'h0);
        @(posedge clk); #1;
        check(rd_valid == 1'b0, "R7 no valid when unselected", {31'h0, rd_valid}, 32'h0);
        check(rd_data == 32'h0, "R5 data zero without valid", rd_data, 32'h0);
    endtask

    initial begin
        #(200000 * 5.0);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        rst = 1'b1; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #0.5;
        check(rd_valid == 1'b0, "R1 valid low after reset", {31'h0, rd_valid}, 32'h0);
        check(narrow_rd == 1'b0, "R1 narrow low after reset", {31'h0, narrow_rd}, 32'h0);
        for (int i = 0; i < 16; i++) do_read(32'(i) << 2, "R1 register zero after reset");

        // R2: upper write lanes dropped
        do_write(32'h0000_0014, 32'hABCD_EF5A);
        do_read(32'h0000_0014, "R2 only low byte stored");
        // R3: low and high address bits ignored
        do_write(32'hFFFF_FFC3 & ~32'h3C | (32'd9 << 2), 32'h0000_00C7);
        do_read(32'h1234_5664, "R3 index from bits 5:2 only");
        do_read(32'h8000_0027, "R3 low address bits ignored");
        // R7: unselected write ignored
        do_idle(1'b1, 32'h0000_0024, 32'h0000_0011);
        do_read(32'h0000_0024, "R7 unselected write ignored");
        // R8: write then immediate read back
        do_write(32'h0000_003C, 32'h0000_00FF);
        do_read(32'h0000_003C, "R8 read after write");
        // R9: reads leave state intact
        for (int i = 0; i < 16; i++) do_read(32'(i) << 2, "R9 first sweep");
        for (int i = 0; i < 16; i++) do_read(32'(i) << 2, "R9 reads preserve registers");

        for (int n = 0; n < 400; n++) begin
            int unsigned op;
            op = $urandom % 4;
            if (op == 0 || op == 1) do_write($urandom, $urandom);
            else if (op == 2) do_read($urandom, "R4 random read matches model");
            else do_idle(1'($urandom), $urandom, $urandom);
        end
        for (int i = 0; i < 16; i++)
            do_read((32'($urandom) & ~32'h3C) | (32'(i) << 2), "R2 final sweep");

        do_idle(1'b0, 32'h0, 32'h0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule